// File: doc/BRIEF.md
# Sequential Reciprocal Square Root Unit

This unit takes a 16-bit unsigned sample X and returns a 12-bit value proportional to 1/sqrt(X). It uses no multiplier and no lookup table. It gives up latency to save area. Two loops share one controller.

The first loop forms a fixed-point square root of X, with three fraction bits. It uses a digit-by-digit method that resolves one root bit per cycle and needs only a compare and a subtract. The second loop divides the constant 2^14 by that root. It is a non-restoring shift-and-add/subtract divider that resolves one quotient bit per cycle.

A request is a one-cycle `start` pulse. The input is captured when `start` is accepted, and the result sits in an output register. Any `start` that arrives while a computation is running is dropped. An input of zero has no finite result. For zero, the unit skips both loops, drives the saturated code and raises an error flag.

Top module: `rsqrt_unit`

## Requirements
- R1: After reset `busy`, `done`, `zeroErr` are 0 and `result` is 0.
- R2: For any nonzero X, `result` equals floor(16384 / floor(sqrt(64·X))) as an unsigned 12-bit value, and `zeroErr` is 0.
- R3: The end points and exact squares are met exactly: X=1 gives 2048, X=65535 gives 8, and X=k·k gives floor(2048/k).
- R4: X=0 gives `result` = 4095 (all ones) and `zeroErr` = 1, with `done` one cycle after the accepting edge.
- R5: A nonzero request that follows a zero request clears `zeroErr`. A nonzero result always lies between 8 and 2048.
- R6: For nonzero X, `done` rises 25 clock cycles after the edge that accepts `start`. `busy` is 1 from the cycle after acceptance until the cycle before `done`, and `busy` is 0 while `done` is 1.
- R7: `done` is high for exactly one cycle per accepted request.
- R8: A `start` pulse seen while `busy` is 1 is ignored. The running result and its timing are unchanged, and no extra `done` follows.
- R9: `result` and `zeroErr` keep their values until the next accepted `start`, whatever `xIn` does in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only when idle |
| xIn | input | 16 | Operand X, sampled with an accepted start |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | 12 | Reciprocal root, registered |
| zeroErr | output | 1 | Last accepted operand was zero |

## Verification
A dense sweep of every X below 1024 covers the region where the root has few significant bits and the quotient changes fastest. A strided sweep to the top of the range finds carry and sign errors in the wide part of the remainder registers. Exact squares separate a wrong rounding direction from a wrong scale, because their expected result has no truncation at all. A zero request placed between two nonzero requests, a start injected mid-run and a long idle with a changing operand test the flag, the drop of a busy start and the holding of the output register.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQRT,
    ST_DIV,
    ST_FIX,
    ST_DONE
  } rsqrtState_e;

  // Strobes issued by the controller to the datapath, one cycle each.
  typedef struct packed {
    logic loadIn;      // capture operand, clear both loops
    logic sqrtStep;    // resolve one root bit
    logic divStep;     // resolve one quotient bit
    logic commit;      // copy quotient to output, clear flag
    logic commitZero;  // saturate output, raise flag
  } rsqrtStrobe_t;

endpackage

// File: rtl/rsqrt_ctrl.sv
module rsqrt_ctrl
  import rsqrt_pkg::*;
#(
  parameter int ROOT_W = 11,
  parameter int Q_W    = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         inZero,
  output rsqrtStrobe_t strobe,
  output logic         busy,
  output logic         done
);
  localparam int MAX_IT = (ROOT_W > Q_W) ? ROOT_W : Q_W;
  localparam int CNT_W  = $clog2(MAX_IT);

  rsqrtState_e state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    strobe   = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        if (inZero) begin
          strobe.commitZero = 1'b1;
          stateNxt          = ST_DONE;
        end else begin
          strobe.loadIn = 1'b1;
          cntNxt        = CNT_W'(ROOT_W - 1);
          stateNxt      = ST_SQRT;
        end
      end
      ST_SQRT: begin
        strobe.sqrtStep = 1'b1;
        if (cnt == '0) begin
          cntNxt   = CNT_W'(Q_W - 1);
          stateNxt = ST_DIV;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      ST_DIV: begin
        strobe.divStep = 1'b1;
        if (cnt == '0) stateNxt = ST_FIX;
        else           cntNxt   = cnt - 1'b1;
      end
      ST_FIX: begin
        strobe.commit = 1'b1;
        stateNxt      = ST_DONE;
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNxt;
      cnt   <= cntNxt;
    end
  end

  assign busy = (state == ST_SQRT) || (state == ST_DIV) || (state == ST_FIX);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/rsqrt_dp.sv
module rsqrt_dp
  import rsqrt_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 3,
  parameter int Q_W    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  xIn,
  input  rsqrtStrobe_t     strobe,
  output logic             inZero,
  output logic [Q_W-1:0]   result,
  output logic             zeroErr
);
  localparam int RAD_W  = IN_W + 2 * FRAC_W;   // radicand X << 2*FRAC_W
  localparam int ROOT_W = RAD_W / 2;           // root with FRAC_W fraction bits
  localparam int SR_W   = ROOT_W + 3;          // root partial remainder
  localparam int REM_W  = ROOT_W + 3;          // signed divider remainder
  // Dividend is 2^(Q_W+FRAC_W-1); its bits above the Q_W shifted ones seed the remainder.
  localparam logic signed [REM_W-1:0] DIV_SEED = REM_W'(1) << (FRAC_W - 1);

  logic [RAD_W-1:0]         rad;
  logic [SR_W-1:0]          sqRem;
  logic [ROOT_W-1:0]        root;
  logic signed [REM_W-1:0]  dRem;
  logic [Q_W-1:0]           quo;

  // Root iteration: bring down two radicand bits, try subtracting 4*root+1.
  logic [SR_W-1:0] sqTry, sqTrial;
  logic            sqFits;
  assign sqTry   = {sqRem[SR_W-3:0], rad[RAD_W-1 -: 2]};
  assign sqTrial = {1'b0, root, 2'b01};
  assign sqFits  = (sqTry >= sqTrial);

  // Divider iteration: sign of current remainder picks subtract or add.
  logic signed [REM_W-1:0] divisor, dShift, dNext;
  assign divisor = $signed(REM_W'(root));
  assign dShift  = dRem <<< 1;
  assign dNext   = dRem[REM_W-1] ? (dShift + divisor) : (dShift - divisor);

  assign inZero = (xIn == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rad   <= '0;
      sqRem <= '0;
      root  <= '0;
      dRem  <= '0;
      quo   <= '0;
    end else if (strobe.loadIn) begin
      rad   <= {xIn, {(2 * FRAC_W){1'b0}}};
      sqRem <= '0;
      root  <= '0;
      dRem  <= DIV_SEED;
      quo   <= '0;
    end else if (strobe.sqrtStep) begin
      rad   <= rad << 2;
      sqRem <= sqFits ? (sqTry - sqTrial) : sqTry;
      root  <= {root[ROOT_W-2:0], sqFits};
    end else if (strobe.divStep) begin
      dRem <= dNext;
      quo  <= {quo[Q_W-2:0], ~dNext[REM_W-1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      zeroErr <= 1'b0;
    end else if (strobe.commitZero) begin
      result  <= '1;
      zeroErr <= 1'b1;
    end else if (strobe.commit) begin
      result  <= quo;
      zeroErr <= 1'b0;
    end
  end

endmodule

// File: rtl/rsqrt_unit.sv
module rsqrt_unit #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 3,
  parameter int Q_W    = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [IN_W-1:0] xIn,
  output logic            busy,
  output logic            done,
  output logic [Q_W-1:0]  result,
  output logic            zeroErr
);
  import rsqrt_pkg::*;

  localparam int ROOT_W = IN_W / 2 + FRAC_W;

  rsqrtStrobe_t strobe;
  logic         inZero;

  rsqrt_ctrl #(.ROOT_W(ROOT_W), .Q_W(Q_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inZero(inZero),
    .strobe(strobe), .busy(busy), .done(done)
  );

  rsqrt_dp #(.IN_W(IN_W), .FRAC_W(FRAC_W), .Q_W(Q_W)) u_dp (
    .clk(clk), .rstN(rstN), .xIn(xIn), .strobe(strobe),
    .inZero(inZero), .result(result), .zeroErr(zeroErr)
  );

endmodule

// File: rtl/rsqrt_unit_chk.sv
module rsqrt_unit_chk #(
  parameter int Q_W = 12
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [Q_W-1:0] result,
  input logic           zeroErr
);
  localparam logic [Q_W-1:0] Q_MAXOK = Q_W'(1) << (Q_W - 1);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r4_zero_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (done && zeroErr) |-> (&result));

  a_r5_nonzero_range: assert property (@(posedge clk) disable iff (!rstN)
    (done && !zeroErr) |-> (result != '0 && result <= Q_MAXOK));

  a_r9_output_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(result) && $stable(zeroErr)));

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

endmodule

bind rsqrt_unit rsqrt_unit_chk #(.Q_W(Q_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .done(done), .result(result), .zeroErr(zeroErr)
);

// File: tb/rsqrt_unit_tb.sv
module rsqrt_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] xIn = '0;
  logic        busy, done, zeroErr;
  logic [11:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rsqrt_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .xIn(xIn),
    .busy(busy), .done(done), .result(result), .zeroErr(zeroErr)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model(input int x);
    longint v = longint'(x) * 64;
    longint r = longint'($sqrt(real'(v)));
    while (r * r > v) r--;
    while ((r + 1) * (r + 1) <= v) r++;
    return int'(16384 / r);
  endfunction

  // Issue one request; returns cycles from accepting edge to done, and busy after acceptance.
  task automatic runOp(input logic [15:0] xv, output int lat, output bit busy1);
    @(negedge clk);
    xIn = xv; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1; busy1 = busy;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic testReset();
    check("R1", busy, 0, "busy after reset");
    check("R1", done, 0, "done after reset");
    check("R1", zeroErr, 0, "zeroErr after reset");
    check("R1", result, 0, "result after reset");
  endtask

  task automatic testExtremes();
    int lat; bit b;
    runOp(16'd1, lat, b);
    check("R3", result, 2048, "X=1");
    check("R6", lat, 25, "latency X=1");
    check("R6", b, 1, "busy after accept");
    runOp(16'hFFFF, lat, b);
    check("R3", result, 8, "X=65535");
    check("R2", zeroErr, 0, "flag X=65535");
    @(negedge clk);
    check("R7", done, 0, "done drops after one cycle");
  endtask

  task automatic testSquares();
    int lat; bit b;
    for (int k = 1; k < 256; k += 7) begin
      runOp(16'(k * k), lat, b);
      check("R3", result, 2048 / k, $sformatf("square k=%0d", k));
    end
  endtask

  task automatic testSweep();
    int lat; bit b;
    for (int x = 1; x < 1024; x++) begin
      runOp(16'(x), lat, b);
      check("R2", result, model(x), $sformatf("dense X=%0d", x));
    end
    for (int x = 1024; x < 65536; x += 61) begin
      runOp(16'(x), lat, b);
      check("R2", result, model(x), $sformatf("strided X=%0d", x));
      if (lat != 25) check("R6", lat, 25, $sformatf("latency X=%0d", x));
    end
  endtask

  task automatic testZero();
    int lat; bit b;
    runOp(16'd0, lat, b);
    check("R4", result, 4095, "zero result");
    check("R4", zeroErr, 1, "zero flag");
    check("R4", lat, 1, "zero latency");
    runOp(16'd100, lat, b);
    check("R5", zeroErr, 0, "flag cleared");
    check("R5", result, 204, "X=100 after zero");
  endtask

  task automatic testBusyStart();
    int lat = 1; int extra = 0;
    @(negedge clk);
    xIn = 16'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    xIn = 16'd0; start = 1'b1;   // must be dropped: unit is busy
    lat = 5;
    @(negedge clk);
    start = 1'b0; lat = 6;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R8", lat, 25, "latency with busy start");
    check("R8", result, 1024, "result X=4 kept");
    check("R8", zeroErr, 0, "no zero flag from dropped start");
    repeat (40) begin
      @(negedge clk);
      if (done) extra++;
    end
    check("R8", extra, 0, "no extra done");
  endtask

  task automatic testHold();
    int lat; bit b;
    runOp(16'd9, lat, b);
    check("R3", result, 682, "X=9");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      xIn = 16'(i * 5000);
    end
    check("R9", result, 682, "result held while idle");
    check("R9", zeroErr, 0, "flag held while idle");
    runOp(16'd0, lat, b);
    repeat (8) begin
      @(negedge clk);
      xIn = 16'd77;
    end
    check("R9", zeroErr, 1, "zero flag held");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testExtremes();
    testSquares();
    testZero();
    testBusyStart();
    testHold();
    testSweep();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule